// File: doc/BRIEF.md
# Five-State Serial Pattern Recognizer

This block watches a serial bit stream, one bit per clock, and raises its output `z` while the stream is inside a run of ones that began with a particular lead-in. It is a Mealy machine, so `z` depends on both the present state and the bit currently on `x`. If `x` changes in the middle of a cycle, `z` follows it without waiting for a clock edge. The transition table is a reduced five-state form of a seven-state machine. Over any input sequence it produces exactly the same outputs as that seven-state machine.

The state register can be stored in one of three encodings: binary count order, Gray order or one-hot. The encoding is chosen with the `ENC` parameter and does not change the input-to-output behaviour. The register value is exposed on `state_code` so that an integrator can see which encoding was built. In one-hot mode, any register value that does not have exactly one bit set is treated as illegal and sends the machine back to its rest state.

Top module: `seqrec_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is REST whatever `x` is. After reset is released, `z` stays 0 until a 1 arrives while in RUN or DIP.
- R2: In REST, 0 stays in REST and 1 goes to LEAD. In LEAD, 0 goes to GAP and 1 goes to RUN. In GAP, 0 goes to REST and 1 goes to RUN. In all three states `z` is 0 for both input values.
- R3: In RUN, 1 stays in RUN with `z`=1, and 0 goes to DIP with `z`=0.
- R4: In DIP, 1 goes to RUN with `z`=1, and 0 goes to REST with `z`=0. `z` is 0 whenever `x` is 0.
- R5: `z` is a combinational function of the present state and `x`. A change on `x` in the middle of a cycle appears on `z` before the next clock edge.
- R6: With `ENC`=ENC_BINARY, `state_code` carries REST=00000, LEAD=00001, GAP=00010, RUN=00011 and DIP=00100.
- R7: With `ENC`=ENC_GRAY, `state_code` carries REST=00000, LEAD=00001, GAP=00011, RUN=00010 and DIP=00110.
- R8: With `ENC`=ENC_ONEHOT, `state_code` carries REST=00001, LEAD=00010, GAP=00100, RUN=01000 and DIP=10000.
- R9: In one-hot mode, a register value with zero bits set or more than one bit set drives `z` to 0 and returns to REST (00001) on the next edge, whatever `x` is.
- R10: For any input sequence, `z` is the same on every cycle as in the seven-state original table, and it is the same in all three encodings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x | input | 1 | Serial input bit |
| z | output | 1 | Mealy recognizer output |
| state_code | output | 5 | Encoded state register value, zero-extended in the 3-bit modes |

## Verification
The bench drives all three encodings in parallel from one input stream. Every cycle, it compares each of them against a seven-state reference model kept in the bench. A wrong merge shows up as a lost or extra 1 on `z`, for example if DIP on a 1 returned to LEAD or if RUN failed to hold on repeated ones. A registered output instead of a Mealy one is caught by toggling `x` in the middle of a cycle while in RUN. Wrong Gray or one-hot codes are caught on `state_code`. A one-hot machine that keeps stepping from an illegal multi-hot or all-zero vector is caught by forcing those vectors into the register and checking that the next code is REST and that `z` stayed low.

// File: rtl/seqrec_pkg.sv
package seqrec_pkg;

    localparam int NUM_PHASES = 5;
    localparam int IDX_W      = 3;
    localparam int CODE_W     = NUM_PHASES;

    typedef enum logic [IDX_W-1:0] {
        ST_REST = 3'd0,
        ST_LEAD = 3'd1,
        ST_GAP  = 3'd2,
        ST_RUN  = 3'd3,
        ST_DIP  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        ENC_BINARY = 2'd0,
        ENC_GRAY   = 2'd1,
        ENC_ONEHOT = 2'd2
    } enc_e;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        phase_e nxt;
        logic   hit;
    } step_t;

    // Encoded register value for a given logical phase.
    function automatic code_t encode(input phase_e p, input enc_e m);
        logic [IDX_W-1:0] idx;
        idx = IDX_W'(p);
        case (m)
            ENC_BINARY: return code_t'(idx);
            ENC_GRAY:   return code_t'(idx ^ (idx >> 1));
            ENC_ONEHOT: return code_t'(1) << idx;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/seqrec_logic.sv
module seqrec_logic
    import seqrec_pkg::*;
(
    input  phase_e phase,
    input  logic   x,
    output phase_e nxt,
    output logic   hit
);
    step_t s;

    always_comb begin
        s = '{nxt: ST_REST, hit: 1'b0};
        case (phase)
            ST_REST: s.nxt = x ? ST_LEAD : ST_REST;
            ST_LEAD: s.nxt = x ? ST_RUN  : ST_GAP;
            ST_GAP:  s.nxt = x ? ST_RUN  : ST_REST;
            ST_RUN: begin
                s.nxt = x ? ST_RUN : ST_DIP;
                s.hit = x;
            end
            ST_DIP: begin
                s.nxt = x ? ST_RUN : ST_REST;
                s.hit = x;
            end
            default: s = '{nxt: ST_REST, hit: 1'b0};
        endcase
    end

    assign nxt = s.nxt;
    assign hit = s.hit;
endmodule

// File: rtl/seqrec_encode.sv
module seqrec_encode
    import seqrec_pkg::*;
#(
    parameter enc_e ENC = ENC_BINARY
) (
    input  phase_e phase,
    output code_t  code
);
    logic [IDX_W-1:0] idx;
    assign idx = IDX_W'(phase);

    generate
        if (ENC == ENC_ONEHOT) begin : g_onehot
            assign code = code_t'(1) << idx;
        end else if (ENC == ENC_GRAY) begin : g_gray
            assign code = code_t'(idx ^ (idx >> 1));
        end else begin : g_binary
            assign code = code_t'(idx);
        end
    endgenerate
endmodule

// File: rtl/seqrec_decode.sv
module seqrec_decode
    import seqrec_pkg::*;
#(
    parameter enc_e ENC = ENC_BINARY
) (
    input  code_t  code,
    output phase_e phase,
    output logic   legal
);
    generate
        if (ENC == ENC_ONEHOT) begin : g_onehot
            // One set bit selects the phase; any other count is illegal.
            always_comb begin
                phase = ST_REST;
                for (int i = 0; i < NUM_PHASES; i++) begin
                    if (code[i]) phase = phase_e'(IDX_W'(i));
                end
                legal = ($countones(code) == 1);
                if (!legal) phase = ST_REST;
            end
        end else begin : g_dense
            // Compare against each legal code; unused codes are illegal.
            always_comb begin
                phase = ST_REST;
                legal = 1'b0;
                for (int i = 0; i < NUM_PHASES; i++) begin
                    if (code == encode(phase_e'(IDX_W'(i)), ENC)) begin
                        phase = phase_e'(IDX_W'(i));
                        legal = 1'b1;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/seqrec_top.sv
module seqrec_top
    import seqrec_pkg::*;
#(
    parameter enc_e ENC = ENC_BINARY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              x,
    output logic              z,
    output logic [CODE_W-1:0] state_code
);
    localparam code_t REST_C = encode(ST_REST, ENC);

    code_t  st_q;
    code_t  nxt_code;
    phase_e cur_ph;
    phase_e nxt_ph;
    logic   legal;
    logic   hit;

    seqrec_decode #(.ENC(ENC)) u_dec (
        .code  (st_q),
        .phase (cur_ph),
        .legal (legal)
    );

    seqrec_logic u_logic (
        .phase (cur_ph),
        .x     (x),
        .nxt   (nxt_ph),
        .hit   (hit)
    );

    seqrec_encode #(.ENC(ENC)) u_enc (
        .phase (nxt_ph),
        .code  (nxt_code)
    );

    always_ff @(posedge clk) begin
        if (rst || !legal) st_q <= REST_C;
        else               st_q <= nxt_code;
    end

    assign z          = legal & hit;
    assign state_code = st_q;
endmodule

// File: rtl/seqrec_chk.sv
module seqrec_chk
    import seqrec_pkg::*;
#(
    parameter enc_e ENC = ENC_BINARY
) (
    input logic              clk,
    input logic              rst,
    input logic              x,
    input logic              z,
    input logic [CODE_W-1:0] state_code
);
    localparam code_t C_REST = encode(ST_REST, ENC);
    localparam code_t C_RUN  = encode(ST_RUN, ENC);
    localparam code_t C_LEAD = encode(ST_LEAD, ENC);

    AST_RESET_TO_REST: assert property (@(posedge clk) rst |=> (state_code == C_REST)); // R1
    AST_REST_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_code == C_REST && x) |=> (state_code == C_LEAD)); // R2
    AST_RUN_HIT: assert property (@(posedge clk) disable iff (rst)
        (state_code == C_RUN && x) |-> z); // R3
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_code == C_RUN && x) |=> (state_code == C_RUN)); // R3
    AST_ZERO_IN_QUIET: assert property (@(posedge clk) disable iff (rst)
        !x |-> !z); // R4

    generate
        if (ENC == ENC_ONEHOT) begin : g_oh
            AST_ILLEGAL_RECOVER: assert property (@(posedge clk) disable iff (rst)
                ($countones(state_code) != 1) |=> (state_code == C_REST)); // R9
            AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (rst)
                ($countones(state_code) != 1) |-> !z); // R9
        end else begin : g_dense
            AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
                state_code[CODE_W-1:IDX_W] == '0); // R6
        end
    endgenerate
endmodule

bind seqrec_top seqrec_chk #(.ENC(ENC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .x          (x),
    .z          (z),
    .state_code (state_code)
);

// File: tb/seqrec_top_test.sv
`timescale 1ns/1ps
module seqrec_top_test;
    import seqrec_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x   = 1'b0;
    logic z_b, z_g, z_o;
    logic [4:0] c_b, c_g, c_o;
    int checks = 0;
    int errors = 0;
    int ms = 0;   // seven-state reference: 0..6 = a..g

    always #2 clk = ~clk;   // 250 MHz

    seqrec_top #(.ENC(ENC_BINARY)) uut      (.clk(clk), .rst(rst), .x(x), .z(z_b), .state_code(c_b));
    seqrec_top #(.ENC(ENC_GRAY))   uut_gray (.clk(clk), .rst(rst), .x(x), .z(z_g), .state_code(c_g));
    seqrec_top #(.ENC(ENC_ONEHOT)) uut_oh   (.clk(clk), .rst(rst), .x(x), .z(z_o), .state_code(c_o));

    // Seven-state original table
    function automatic int ref_next(int s, logic b);
        case (s)
            0: return b ? 1 : 0;
            1: return b ? 3 : 2;
            2: return b ? 3 : 0;
            3: return b ? 5 : 4;
            4: return b ? 5 : 0;
            5: return b ? 5 : 6;
            6: return b ? 5 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic logic ref_z(int s, logic b);
        return b && (s >= 3);
    endfunction

    function automatic int merged(int s);
        if (s == 5) return 3;
        if (s == 6) return 4;
        return s;
    endfunction

    function automatic logic [4:0] exp_bin(int p);
        return 5'(p);
    endfunction

    function automatic logic [4:0] exp_gray(int p);
        logic [4:0] t [5] = '{5'b00000, 5'b00001, 5'b00011, 5'b00010, 5'b00110};
        return t[p];
    endfunction

    function automatic logic [4:0] exp_oh(int p);
        return 5'b00001 << p;
    endfunction

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_codes(input string tag);
        int p = merged(ms);
        chk({"R6 binary code ", tag}, c_b, exp_bin(p));
        chk({"R7 gray code ", tag},   c_g, exp_gray(p));
        chk({"R8 one-hot code ", tag}, c_o, exp_oh(p));
    endtask

    // Apply one bit, check z (R10) and codes, then advance the model.
    task automatic step(input logic b, input string tag);
        logic e;
        @(negedge clk);
        x = b;
        #0.5;
        e = ref_z(ms, b);
        chk({"R10 z binary ", tag}, 5'(z_b), 5'(e));
        chk({"R10 z gray ", tag},   5'(z_g), 5'(e));
        chk({"R10 z one-hot ", tag}, 5'(z_o), 5'(e));
        chk_codes(tag);
        @(posedge clk);
        ms = ref_next(ms, b);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        x = 1'b1;
        @(posedge clk);
        ms = 0;
        @(negedge clk);
        rst = 1'b0;
        x = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #0.5;
        chk_codes("R1 after reset");
        chk("R1 z quiet after reset", 5'({z_b, z_g, z_o}), 5'b0);
        step(1'b1, "R1 first one");
        step(1'b0, "R1 then zero");
        // Mid-run reset from RUN with x held high
        step(1'b1, "R1 pre");
        step(1'b1, "R1 run");
        do_reset();
        #0.5;
        chk_codes("R1 reset from run");
    endtask

    // Walk every transition of the reduced table (R2, R3, R4).
    task automatic t_table();
        string pre [5] = '{"", "1", "10", "11", "110"};
        string tg  [5] = '{"R2 rest", "R2 lead", "R2 gap", "R3 run", "R4 dip"};
        for (int s = 0; s < 5; s++) begin
            for (int b = 0; b < 2; b++) begin
                do_reset();
                for (int k = 0; k < pre[s].len(); k++)
                    step(pre[s][k] == "1", {tg[s], " prefix"});
                step(b[0], tg[s]);
                @(negedge clk);
                #0.5;
                chk_codes({tg[s], " next"});
            end
        end
    endtask

    // z follows x within a cycle (R5).
    task automatic t_mealy();
        do_reset();
        step(1'b1, "R5 lead");
        step(1'b1, "R5 run");
        @(negedge clk);
        x = 1'b0;
        #0.5;
        chk("R5 z low with x=0", 5'({z_b, z_g, z_o}), 5'b000);
        x = 1'b1;
        #0.5;
        chk("R5 z high after x rises", 5'({z_b, z_g, z_o}), 5'b111);
        x = 1'b0;
        #0.5;
        chk("R5 z low after x falls", 5'({z_b, z_g, z_o}), 5'b000);
        @(posedge clk);
        ms = ref_next(ms, 1'b0);
        step(1'b1, "R5 dip to run");
    endtask

    task automatic t_illegal(input logic [4:0] bad);
        do_reset();
        @(negedge clk);
        force uut_oh.st_q = bad;
        x = 1'b1;
        #0.5;
        release uut_oh.st_q;
        #0.5;
        chk("R9 z low in illegal state", 5'(z_o), 5'b0);
        @(posedge clk);
        @(negedge clk);
        #0.5;
        chk("R9 one-hot recovers to rest", c_o, 5'b00001);
    endtask

    // Long pseudo-random stream against the seven-state model (R10).
    task automatic t_stream();
        logic [15:0] lfsr = 16'hACE1;
        do_reset();
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | (i[3] & lfsr[1]), "R10 stream");
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_table();
        t_mealy();
        t_illegal(5'b00000);
        t_illegal(5'b01010);
        t_illegal(5'b11111);
        t_stream();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule